// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block sits between the two bus lines of a serial non-volatile memory and its internal byte array. It samples the clock and data lines with the system clock and passes each through a synchronizer and a glitch filter. It then recognises the start and stop conditions and decodes the command stream. A command opens with a control byte that carries a 7-bit device identifier and a read/write flag. A write command then carries a word address and one or more data bytes. A read command streams bytes out of the array, starting at the current address pointer.

The filtered lines feed a single controller built in the two-process style. The controller acknowledges each accepted byte by pulling the data line low. It shifts read data out most significant bit first. It holds a write until the closing stop condition, then fires a write strobe to the array and starts a write-cycle timer. While that timer runs, the controller ignores all bus traffic. The data line is driven only through an open-drain enable, and that enable moves a programmable number of clocks after the filtered clock line has fallen.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset, `standby_o` is 1, and `busy_o`, `sda_oe_o` and `mem_we_o` are 0.
- R2: A falling data line while the clock is high (a start condition) leaves standby and begins a command. A control byte whose bits [7:1] equal `DEV_ID` is acknowledged. Any other control byte is not acknowledged, and the block returns to standby.
- R3: For each accepted control, address or write-data byte, the block pulls the data line low (`sda_oe_o` = 1) throughout the ninth clock pulse.
- R4: A write command has bit 0 of the control byte equal to 0, followed by an address byte and data bytes. A stop condition after at least one data byte gives exactly one single-cycle `mem_we_o`. In that cycle, `mem_addr_o` is the address byte and `mem_wdata_o` is the last data byte received.
- R5: After the write strobe, `busy_o` stays high for exactly `WR_CYCLES` clocks. When it drops, `standby_o` returns.
- R6: While `busy_o` is high, start conditions and bytes are ignored: there is no acknowledge, `sda_oe_o` stays 0, and there is no write strobe.
- R7: A read command has bit 0 of the control byte equal to 1. After the acknowledge, the block sends the byte at the current address pointer, most significant bit first. A 0 bit is sent as `sda_oe_o` = 1.
- R8: When the master acknowledges a read byte, the next byte comes from the pointer plus one. The pointer wraps from the top address to 0.
- R9: After a read byte that the master does not acknowledge, the block leaves the data line released. A following stop condition returns it to standby.
- R10: A pulse on either line shorter than `FILT_CYCLES` system clocks is rejected. It creates no start condition and no clock edge.
- R11: `sda_oe_o` asserts only while the filtered clock line is low.
- R12: A repeated start condition in the middle of a command restarts decoding with a new control byte. The address pointer keeps the value loaded by the interrupted write, and no write strobe is issued for that write.
- R13: A write command that is stopped after its address byte, with no data byte, issues no strobe and does not go busy. It only loads the address pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| mem_addr_o | output | AW | Array address (pointer, also used for writes) |
| mem_wdata_o | output | 8 | Byte to write into the array |
| mem_we_o | output | 1 | Single-cycle write strobe |
| mem_rdata_i | input | 8 | Array read data for `mem_addr_o` |
| busy_o | output | 1 | Internal write cycle running |
| standby_o | output | 1 | Idle with no internal operation pending |

## Verification
The bench sends a two-clock pulse on the data line of an idle bus. A filter that is too short would take this pulse as a start condition and drop standby. The bench also sends a two-clock pulse on the clock line inside a control byte. A filter that is too short would shift in an extra bit, and the byte would be refused. A start attempt made during the write cycle must draw no acknowledge; a design that fails to block the bus while busy would answer it. A sequential read that starts at address 0xFE must wrap to 0x00. A multi-byte write must store only its last byte. An address-only write and a write cut off by a repeated start must leave the array untouched; a design that strobes on any stop condition would corrupt the array.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT_STOP
    } st_t;

    typedef enum logic [1:0] {
        K_CTRL, K_WADDR, K_WDATA
    } kind_t;
endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
    parameter int FILT_CYCLES = 3,
    parameter bit RST_VAL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
        logic          out;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d    = q;
        d.s1 = line_i;
        d.s2 = q.s1;
        if (q.s2 == q.out) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(FILT_CYCLES - 1)) begin
            d.out = q.s2;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1  <= RST_VAL;
            q.s2  <= RST_VAL;
            q.cnt <= '0;
            q.out <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.out;
endmodule

// File: rtl/tw_wr_timer.sv
module tw_wr_timer #(
    parameter int WR_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (start_i)
            cnt_d = CW'(WR_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
        else
            cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
    parameter logic [6:0] DEV_ID      = 7'h50,
    parameter int         AW          = 8,
    parameter int         FILT_CYCLES = 3,
    parameter int         HOLD_CYCLES = 2,
    parameter int         WR_CYCLES   = 500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [7:0]    mem_wdata_o,
    output logic          mem_we_o,
    input  logic [7:0]    mem_rdata_i,
    output logic          busy_o,
    output logic          standby_o
);
    import tw_mem_pkg::*;

    localparam int HW = $clog2(HOLD_CYCLES + 2);

    // line conditioning: index 0 = clock line, 1 = data line
    logic [1:0] raw_lines, filt_lines;
    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_flt
        tw_line_filter #(
            .FILT_CYCLES(FILT_CYCLES),
            .RST_VAL    (1'b1)
        ) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
        );
    end

    logic scl_f, sda_f;
    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    typedef struct packed {
        st_t           st;
        kind_t         kind;
        logic [3:0]    bit_cnt;
        logic [7:0]    sh;
        logic [AW-1:0] addr;
        logic [7:0]    wdata;
        logic          wpend;
        logic          rd;
        logic          mack;
        logic          scl_p;
        logic          sda_p;
        logic          oe;
        logic          oe_tgt;
        logic [HW-1:0] dly;
        logic          we;
    } ctl_t;

    ctl_t q, d;
    logic busy;
    logic scl_rise, scl_fall, start_c, stop_c;
    logic sched_en, sched_val;

    assign scl_rise = scl_f & ~q.scl_p;
    assign scl_fall = ~scl_f & q.scl_p;
    assign start_c  = q.scl_p & scl_f & q.sda_p & ~sda_f;
    assign stop_c   = q.scl_p & scl_f & ~q.sda_p & sda_f;

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        d.scl_p   = scl_f;
        d.sda_p   = sda_f;
        sched_en  = 1'b0;
        sched_val = 1'b0;

        // delayed output update
        if (q.dly != '0) begin
            d.dly = q.dly - HW'(1);
            if (q.dly == HW'(1)) d.oe = q.oe_tgt;
        end

        if (busy) begin
            d.st    = ST_IDLE;
            d.oe    = 1'b0;
            d.dly   = '0;
            d.wpend = 1'b0;
        end else if (stop_c) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.dly = '0;
            if (q.wpend) begin
                d.we    = 1'b1;
                d.wpend = 1'b0;
            end
        end else if (start_c) begin
            d.st      = ST_RX;
            d.kind    = K_CTRL;
            d.bit_cnt = '0;
            d.oe      = 1'b0;
            d.dly     = '0;
            d.wpend   = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh      = {q.sh[6:0], sda_f};
                        d.bit_cnt = q.bit_cnt + 4'd1;
                    end else if (scl_fall && q.bit_cnt == 4'd8) begin
                        unique case (q.kind)
                            K_CTRL: begin
                                if (q.sh[7:1] == DEV_ID) begin
                                    d.rd      = q.sh[0];
                                    d.kind    = K_WADDR;
                                    d.st      = ST_RX_ACK;
                                    sched_en  = 1'b1;
                                    sched_val = 1'b1;
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            K_WADDR: begin
                                d.addr    = AW'(q.sh);
                                d.kind    = K_WDATA;
                                d.st      = ST_RX_ACK;
                                sched_en  = 1'b1;
                                sched_val = 1'b1;
                            end
                            default: begin
                                d.wdata   = q.sh;
                                d.wpend   = 1'b1;
                                d.st      = ST_RX_ACK;
                                sched_en  = 1'b1;
                                sched_val = 1'b1;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.bit_cnt = '0;
                        sched_en  = 1'b1;
                        if (q.rd) begin
                            d.sh      = mem_rdata_i;
                            d.st      = ST_TX;
                            sched_val = ~mem_rdata_i[7];
                        end else begin
                            d.st      = ST_RX;
                            sched_val = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        sched_en = 1'b1;
                        if (q.bit_cnt == 4'd7) begin
                            sched_val = 1'b0;
                            d.st      = ST_TX_ACK;
                            d.addr    = q.addr + AW'(1);
                        end else begin
                            d.sh      = {q.sh[6:0], 1'b0};
                            d.bit_cnt = q.bit_cnt + 4'd1;
                            sched_val = ~q.sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_f;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.sh      = mem_rdata_i;
                            d.bit_cnt = '0;
                            d.st      = ST_TX;
                            sched_en  = 1'b1;
                            sched_val = ~mem_rdata_i[7];
                        end else begin
                            d.st = ST_WAIT_STOP;
                        end
                    end
                end
                default: ;
            endcase

            if (sched_en) begin
                if (HOLD_CYCLES == 0) begin
                    d.oe  = sched_val;
                    d.dly = '0;
                end else begin
                    d.oe_tgt = sched_val;
                    d.dly    = HW'(HOLD_CYCLES);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    tw_wr_timer #(
        .WR_CYCLES(WR_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(q.we),
        .busy_o (busy)
    );

    assign sda_oe_o    = q.oe;
    assign mem_addr_o  = q.addr;
    assign mem_wdata_o = q.wdata;
    assign mem_we_o    = q.we;
    assign busy_o      = busy;
    assign standby_o   = (q.st == ST_IDLE) & ~busy & ~q.we;
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk #(
    parameter int WR_CYCLES = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic sda_oe,
    input logic mem_we,
    input logic busy,
    input logic standby
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 32'd1;
        else           run_q <= '0;
    end

    // R11
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    // R4
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R6
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!mem_we && !sda_oe));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 32'(WR_CYCLES)));

    // R1
    standby_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!busy && !sda_oe));
endmodule

bind tw_mem_slave tw_mem_slave_chk #(.WR_CYCLES(WR_CYCLES)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_f  (scl_f),
    .sda_oe (sda_oe_o),
    .mem_we (mem_we_o),
    .busy   (busy_o),
    .standby(standby_o)
);

// File: tb/tw_mem_slave_tb_top.sv
`timescale 1ns/1ps
module tw_mem_slave_tb_top;
    localparam int AW   = 8;
    localparam int WR   = 2000;
    localparam int Q    = 16;
    localparam logic [7:0] CW_WR = 8'hA0;
    localparam logic [7:0] CW_RD = 8'hA1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, mem_we, busy, standby;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic sda_line;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    tw_mem_slave #(
        .DEV_ID(7'h50), .AW(AW), .FILT_CYCLES(3), .HOLD_CYCLES(2), .WR_CYCLES(WR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .busy_o(busy),
        .standby_o(standby)
    );

    logic [7:0] mem     [0:255];
    logic [7:0] exp_mem [0:255];
    assign mem_rdata = mem[mem_addr];

    function automatic logic [7:0] seed_val(int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = seed_val(i);
            exp_mem[i] = seed_val(i);
        end
    end

    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    // monitors
    int wr_cnt = 0;
    logic [7:0] last_a, last_d;
    int busy_run = 0, busy_last = 0;
    int oe_viol = 0;
    logic oe_prev = 1'b0;

    always @(negedge clk) begin
        if (mem_we) begin
            wr_cnt++;
            last_a = mem_addr;
            last_d = mem_wdata;
        end
        if (busy) busy_run++;
        else if (busy_run != 0) begin
            busy_last = busy_run;
            busy_run  = 0;
        end
        if (rst_n && sda_oe && !oe_prev && scl_m) oe_viol++;
        oe_prev = sda_oe;
    end

    int total = 0, bad = 0;
    bit done = 1'b0;
    bit glitch_scl = 1'b0;

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic write_bit(logic b);
        sda_m = b;
        if (glitch_scl) begin
            wait_clk(4);
            scl_m = 1'b1; wait_clk(2);
            scl_m = 1'b0; wait_clk(Q - 6);
            glitch_scl = 1'b0;
        end else begin
            wait_clk(Q);
        end
        scl_m = 1'b1; wait_clk(2 * Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        b = sda_line; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic write_byte(logic [7:0] v, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) write_bit(v[i]);
        read_bit(b);
        ack = !b;
    endtask

    task automatic read_byte(bit give_ack, output logic [7:0] v);
        logic b;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            read_bit(b);
            v = {v[6:0], b};
        end
        write_bit(!give_ack);
    endtask

    task automatic wait_idle();
        wait_clk(4);
        while (busy) wait_clk(1);
        wait_clk(4);
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] v, string req);
        bit k0, k1, k2;
        int w0;
        w0 = wr_cnt;
        bus_start();
        write_byte(CW_WR, k0);
        write_byte(a, k1);
        write_byte(v, k2);
        bus_stop();
        check(k0 && k1 && k2, {req, " acks"}, {k0, k1, k2}, 3'b111);
        check(wr_cnt == w0 + 1 && last_a == a && last_d == v, {req, " strobe"},
              {last_a, last_d}, {a, v});
        exp_mem[a] = v;
        wait_idle();
    endtask

    task automatic do_read(logic [7:0] a, int n, string req);
        bit k0, k1, k2;
        logic [7:0] v;
        bus_start();
        write_byte(CW_WR, k0);
        write_byte(a, k1);
        bus_start();
        write_byte(CW_RD, k2);
        check(k0 && k1 && k2, {req, " acks"}, {k0, k1, k2}, 3'b111);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, v);
            check(v == exp_mem[8'(a + i)], req, v, exp_mem[8'(a + i)]);
        end
        bus_stop();
        wait_clk(8);
    endtask

    initial begin
        bit k0, k1, k2, k3;
        logic [7:0] v;
        int w0;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R1 reset state
        check(standby && !busy && !sda_oe && !mem_we, "R1 reset",
              {standby, busy, sda_oe, mem_we}, 4'b1000);

        // R10 short data-line pulse on idle bus
        sda_m = 1'b0; wait_clk(2); sda_m = 1'b1; wait_clk(20);
        check(standby == 1'b1, "R10 sda glitch", standby, 1);

        // R2 wrong identifier: no ack, back to standby
        bus_start();
        check(standby == 1'b0, "R2 start leaves standby", standby, 0);
        write_byte(8'hA4, k0);
        wait_clk(4);
        check(!k0, "R2 mismatch nack", k0, 0);
        check(standby == 1'b1, "R2 mismatch standby", standby, 1);
        bus_stop();

        // R10 clock-line glitch inside control byte, R3/R4/R5 write
        w0 = wr_cnt;
        bus_start();
        glitch_scl = 1'b1;
        write_byte(CW_WR, k0);
        check(k0, "R10 scl glitch ack", k0, 1);
        write_byte(8'h21, k1);
        write_byte(8'h9C, k2);
        check(k1 && k2, "R3 addr/data ack", {k1, k2}, 2'b11);
        bus_stop();
        check(wr_cnt == w0 + 1 && last_a == 8'h21 && last_d == 8'h9C, "R4 strobe",
              {last_a, last_d}, 16'h219C);
        exp_mem[8'h21] = 8'h9C;
        check(busy == 1'b1 && standby == 1'b0, "R5 busy after stop", {busy, standby}, 2'b10);

        // R6 bus ignored while busy
        w0 = wr_cnt;
        bus_start();
        write_byte(CW_WR, k3);
        bus_stop();
        check(busy == 1'b1, "R6 still busy", busy, 1);
        check(!k3, "R6 no ack while busy", k3, 0);
        check(wr_cnt == w0, "R6 no strobe while busy", wr_cnt, w0);
        wait_idle();
        check(busy_last == WR, "R5 busy length", busy_last, WR);
        check(standby == 1'b1, "R5 standby after write", standby, 1);

        // R4 multi-byte write: last byte wins
        w0 = wr_cnt;
        bus_start();
        write_byte(CW_WR, k0);
        write_byte(8'h40, k1);
        write_byte(8'h11, k2);
        write_byte(8'h22, k2);
        write_byte(8'h33, k3);
        bus_stop();
        check(wr_cnt == w0 + 1 && last_a == 8'h40 && last_d == 8'h33, "R4 last wins",
              {last_a, last_d}, 16'h4033);
        exp_mem[8'h40] = 8'h33;
        wait_idle();

        // R13 address-only write, then R7/R9 current-address read
        w0 = wr_cnt;
        bus_start();
        write_byte(CW_WR, k0);
        write_byte(8'h10, k1);
        bus_stop();
        wait_clk(8);
        check(wr_cnt == w0 && !busy, "R13 no strobe", {wr_cnt - w0, busy}, 0);
        bus_start();
        write_byte(CW_RD, k2);
        read_byte(1'b0, v);
        check(v == exp_mem[8'h10], "R7 current read", v, exp_mem[8'h10]);
        wait_clk(2);
        check(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
        bus_stop();
        wait_clk(4);
        check(standby == 1'b1, "R9 standby after stop", standby, 1);

        // R12 write cut by repeated start: no strobe, pointer kept
        w0 = wr_cnt;
        bus_start();
        write_byte(CW_WR, k0);
        write_byte(8'h40, k1);
        write_byte(8'h77, k2);
        bus_start();
        write_byte(CW_RD, k3);
        read_byte(1'b0, v);
        bus_stop();
        wait_clk(8);
        check(v == exp_mem[8'h40], "R12 restart read", v, exp_mem[8'h40]);
        check(wr_cnt == w0, "R12 no strobe", wr_cnt, w0);

        // R8 sequential read with wrap
        do_read(8'hFE, 4, "R8 wrap read");
        do_read(8'h20, 3, "R8 seq read");

        // random write/read-back
        void'($urandom(32'h1234));
        for (int it = 0; it < 6; it++) begin
            logic [7:0] ra, rv;
            ra = 8'($urandom);
            rv = 8'($urandom);
            do_write(ra, rv, "R4 random write");
            do_read(ra, 2, "R7 random read");
        end

        check(oe_viol == 0, "R11 oe while scl high", oe_viol, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule